// File: doc/BRIEF.md
# Banked Register and Bit-Addressable Internal Data Memory

This block is the internal data store of a small 8-bit controller core. It holds two separate 128-byte RAMs and forwards a third region, the special-register window, to an external read/write bus. A single request port carries one access per cycle. The access kind decides where an address lands. Direct byte accesses above 7FH go to the special-register bus. Indirect accesses above 7FH reach the second RAM. Register-number accesses pick one of four banks of eight working registers. Bit accesses are translated into a byte address and a bit position.

The core drives `req_op`, `req_addr` and write data, and collects read results one cycle later on `rd_data` or `rd_bit`. The active bank comes from bits 4 and 3 of the status word, which lives at special-register address D0H. The block watches every write that reaches that address over its own bus and keeps a copy of those two bits. A bit write is a two-cycle read-modify-write. `busy` flags its second cycle, and requests presented during that cycle are dropped.

Top module: `banked_data_ram`

## Requirements
- R1: After reset `busy` and `rd_valid` are low and bank 0 is active, so register number 0 reads address 00H.
- R2: Operation codes on `req_op` are 0 direct read, 1 direct write, 2 indirect read, 3 indirect write, 4 register read, 5 register write, 6 bit read and 7 bit write. A direct access to 00H-7FH uses the lower RAM. A read result appears with `rd_valid` high in the cycle after the request.
- R3: A direct access to 80H-FFH is placed on the special-register bus in the same cycle: `sfr_rd` with `sfr_rdata` captured for a read, or `sfr_wr` with `sfr_wdata` for a write. `sfr_rd` and `sfr_wr` are never high together.
- R4: An indirect access takes its address from working register R0 (`req_addr[0]`=0) or R1 (`req_addr[0]`=1) of the active bank. A pointer below 80H selects the lower RAM. A pointer of 80H or above selects the upper RAM, which is distinct from the special-register window.
- R5: Register number n (`req_addr[2:0]`) in bank b addresses lower RAM byte 8*b+n.
- R6: The bank follows bits 4:3 of any byte written to address D0H on the special-register bus, whether by a byte write or by a bit write-back. A request issued in the cycle after that write already uses the new bank.
- R7: Bit addresses 00H-7FH select bit (a mod 8) of lower RAM byte 20H + a/8. For example, bit address 78H is bit 0 of byte 2FH.
- R8: Bit addresses 80H-FFH select bit (a mod 8) of the special register at a with its low three bits cleared.
- R9: A bit write reads the byte in its first cycle and writes it back in the second. Only the addressed bit changes. `busy` is high for exactly that second cycle, and any request presented while `busy` is high is ignored.
- R10: A bit read returns the addressed bit on `rd_bit` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 8 | Byte address, pointer select, register number or bit address |
| req_wdata | input | 8 | Write data for byte writes |
| req_bit | input | 1 | Value for a bit write |
| busy | output | 1 | Bit write-back cycle; requests are ignored |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 8 | Byte read result |
| rd_bit | output | 1 | Bit read result |
| sfr_addr | output | 8 | Special-register bus address |
| sfr_rd | output | 1 | Special-register read strobe |
| sfr_wr | output | 1 | Special-register write strobe |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, same cycle |

## Verification
The same numeric address is reached through several access kinds, and each kind must land in different storage. Direct and indirect reads of C0H must differ (upper RAM against the register window). Register-number reads of R0 must return a different byte after each bank change, whether the bank was changed by a byte write or by a bit set or clear on D3H/D4H. Bit writes are tried on a byte that is all ones (clearing bit 0 of 2FH), on zero bytes, and on a special register. The following byte read shows that the neighbouring bits survived. A byte write presented while `busy` is high is shown to be dropped by reading its target afterwards.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int BYTE_W     = 8;
  localparam int HALF_DEPTH = 128;
  localparam int HALF_AW    = $clog2(HALF_DEPTH);
  localparam int BANK_LSB   = 3;
  localparam logic [7:0] STATUS_ADDR   = 8'hD0;
  localparam logic [7:0] BIT_AREA_BASE = 8'h20;

  typedef enum logic [2:0] {
    OP_DIR_RD = 3'd0, OP_DIR_WR = 3'd1, OP_IND_RD = 3'd2, OP_IND_WR = 3'd3,
    OP_REG_RD = 3'd4, OP_REG_WR = 3'd5, OP_BIT_RD = 3'd6, OP_BIT_WR = 3'd7
  } op_e;

  typedef enum logic [1:0] {SP_LOWER = 2'd0, SP_UPPER = 2'd1, SP_SFR = 2'd2} space_e;

  // working register n of bank b sits at 8*b + n
  function automatic logic [7:0] reg_byte(input logic [1:0] bank, input logic [2:0] rn);
    return {3'b000, bank, rn};
  endfunction

  // byte holding a given bit address
  function automatic logic [7:0] bit_byte(input logic [7:0] ba);
    if (ba[7]) return {ba[7:3], 3'b000};
    return BIT_AREA_BASE + {4'b0000, ba[6:3]};
  endfunction

  function automatic logic [7:0] bit_merge(input logic [7:0] b, input logic [2:0] pos,
                                           input logic v);
    logic [7:0] r;
    r = b;
    r[pos] = v;
    return r;
  endfunction
endpackage

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  parameter int N_RD  = 1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_RD-1:0][AW-1:0]     rd_addr,
  output logic [N_RD-1:0][WIDTH-1:0]  rd_data,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  generate
    for (genvar g = 0; g < N_RD; g++) begin : g_rd
      assign rd_data[g] = mem_q[rd_addr[g]];
    end
  endgenerate
endmodule

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
(
  input  op_e          op,
  input  logic [7:0]   addr,
  input  logic [1:0]   bank,
  input  logic [7:0]   ptr,
  output logic [6:0]   ptr_idx,
  output space_e       space,
  output logic [7:0]   byte_addr,
  output logic [2:0]   bit_pos,
  output logic         is_write,
  output logic         is_bit
);
  logic [7:0] ptr_full;

  always_comb begin
    ptr_full  = reg_byte(bank, {2'b00, addr[0]});
    ptr_idx   = ptr_full[6:0];
    is_write  = op inside {OP_DIR_WR, OP_IND_WR, OP_REG_WR, OP_BIT_WR};
    is_bit    = op inside {OP_BIT_RD, OP_BIT_WR};
    bit_pos   = addr[2:0];
    byte_addr = addr;
    space     = SP_LOWER;
    unique case (op)
      OP_DIR_RD, OP_DIR_WR: begin
        byte_addr = addr;
        space     = addr[7] ? SP_SFR : SP_LOWER;
      end
      OP_IND_RD, OP_IND_WR: begin
        byte_addr = ptr;
        space     = ptr[7] ? SP_UPPER : SP_LOWER;
      end
      OP_REG_RD, OP_REG_WR: begin
        byte_addr = reg_byte(bank, addr[2:0]);
        space     = SP_LOWER;
      end
      default: begin
        byte_addr = bit_byte(addr);
        space     = addr[7] ? SP_SFR : SP_LOWER;
      end
    endcase
  end
endmodule

// File: rtl/banked_data_ram.sv
module banked_data_ram
  import idm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [2:0]  req_op,
  input  logic [7:0]  req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        req_bit,
  output logic        busy,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_bit,
  output logic [7:0]  sfr_addr,
  output logic        sfr_rd,
  output logic        sfr_wr,
  output logic [7:0]  sfr_wdata,
  input  logic [7:0]  sfr_rdata
);
  op_e op;
  assign op = op_e'(req_op);

  logic [1:0] bank_q;
  logic       busy_q;
  space_e     hold_space_q;
  logic [7:0] hold_addr_q, hold_byte_q;
  logic       rd_valid_q, rd_bit_q;
  logic [7:0] rd_data_q;

  // named internal events
  logic accept, plain_wr, bit_wr_start, read_acc;

  space_e     rt_space;
  logic [7:0] rt_byte;
  logic [6:0] rt_ptr_idx;
  logic [2:0] rt_bit_pos;
  logic       rt_is_write, rt_is_bit;

  logic [1:0][HALF_AW-1:0] lo_raddr;
  logic [1:0][BYTE_W-1:0]  lo_rdata;
  logic [0:0][HALF_AW-1:0] up_raddr;
  logic [0:0][BYTE_W-1:0]  up_rdata;
  logic                    lo_we, up_we;
  logic [HALF_AW-1:0]      wr_idx;
  logic [BYTE_W-1:0]       wr_byte;
  logic [7:0]              cur_byte;

  idm_route route_i (
    .op(op), .addr(req_addr), .bank(bank_q), .ptr(lo_rdata[1]),
    .ptr_idx(rt_ptr_idx), .space(rt_space), .byte_addr(rt_byte),
    .bit_pos(rt_bit_pos), .is_write(rt_is_write), .is_bit(rt_is_bit)
  );

  assign accept       = req_valid && !busy_q;
  assign plain_wr     = accept && rt_is_write && !rt_is_bit;
  assign bit_wr_start = accept && rt_is_write && rt_is_bit;
  assign read_acc     = accept && !rt_is_write;

  assign lo_raddr[0] = rt_byte[HALF_AW-1:0];
  assign lo_raddr[1] = rt_ptr_idx;
  assign up_raddr[0] = rt_byte[HALF_AW-1:0];

  assign wr_idx  = busy_q ? hold_addr_q[HALF_AW-1:0] : rt_byte[HALF_AW-1:0];
  assign wr_byte = busy_q ? hold_byte_q : req_wdata;
  assign lo_we   = (plain_wr && rt_space == SP_LOWER) || (busy_q && hold_space_q == SP_LOWER);
  assign up_we   = (plain_wr && rt_space == SP_UPPER) || (busy_q && hold_space_q == SP_UPPER);

  idm_ram #(.DEPTH(HALF_DEPTH), .WIDTH(BYTE_W), .N_RD(2)) lower_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(lo_raddr), .rd_data(lo_rdata),
    .wr_en(lo_we), .wr_addr(wr_idx), .wr_data(wr_byte)
  );

  idm_ram #(.DEPTH(HALF_DEPTH), .WIDTH(BYTE_W), .N_RD(1)) upper_i (
    .clk(clk), .rst_n(rst_n), .rd_addr(up_raddr), .rd_data(up_rdata),
    .wr_en(up_we), .wr_addr(wr_idx), .wr_data(wr_byte)
  );

  assign sfr_wr    = (plain_wr && rt_space == SP_SFR) || (busy_q && hold_space_q == SP_SFR);
  assign sfr_rd    = accept && !plain_wr && rt_space == SP_SFR;
  assign sfr_addr  = busy_q ? hold_addr_q : rt_byte;
  assign sfr_wdata = wr_byte;

  always_comb begin
    unique case (rt_space)
      SP_UPPER: cur_byte = up_rdata[0];
      SP_SFR:   cur_byte = sfr_rdata;
      default:  cur_byte = lo_rdata[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q       <= '0;
      busy_q       <= 1'b0;
      hold_space_q <= SP_LOWER;
      hold_addr_q  <= '0;
      hold_byte_q  <= '0;
      rd_valid_q   <= 1'b0;
      rd_data_q    <= '0;
      rd_bit_q     <= 1'b0;
    end else begin
      busy_q     <= bit_wr_start;
      rd_valid_q <= read_acc;
      if (bit_wr_start) begin
        hold_space_q <= rt_space;
        hold_addr_q  <= rt_byte;
        hold_byte_q  <= bit_merge(cur_byte, rt_bit_pos, req_bit);
      end
      if (read_acc) begin
        rd_data_q <= cur_byte;
        rd_bit_q  <= cur_byte[rt_bit_pos];
      end
      if (sfr_wr && sfr_addr == STATUS_ADDR) bank_q <= sfr_wdata[BANK_LSB +: 2];
    end
  end

  assign busy     = busy_q;
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;
  assign rd_bit   = rd_bit_q;

  // R9
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !busy_q);
  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_valid && req_op == 3'd7));
  // R9
  wb_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($countones(wr_byte ^ $past(cur_byte)) <= 1));
  // R6
  bank_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bank_q) |-> $past(sfr_wr && sfr_addr == STATUS_ADDR));
  // R3
  sfr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_wr && sfr_rd));
  // R2
  rdv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_q |-> $past(req_valid && !busy_q && !req_op[0]));
  // R8
  sfr_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_rd && rt_is_bit) |-> (sfr_addr[2:0] == 3'b000 && sfr_addr[7]));
endmodule

// File: tb/banked_data_ram_tb_top.sv
`timescale 1ns/1ps
module banked_data_ram_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       req_bit = 1'b0;
  logic       busy, rd_valid, rd_bit, sfr_rd, sfr_wr;
  logic [7:0] rd_data, sfr_addr, sfr_wdata, sfr_rdata;

  logic [7:0] sfr_mem [256];
  logic [7:0] m_lo [128];
  logic [7:0] m_up [128];
  int m_bank = 0;
  int n_vec = 0, n_bad = 0;

  typedef struct { logic [7:0] data; logic is_bit; string tag; } exp_t;
  exp_t exp_q[$];

  banked_data_ram dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_bit(rd_bit),
    .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  // special-register device on the external bus
  assign sfr_rdata = sfr_mem[sfr_addr];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) sfr_mem[i] <= 8'(i * 7 + 3);
    end else if (sfr_wr) begin
      sfr_mem[sfr_addr] <= sfr_wdata;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected reads as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("unexpected rd_valid R2", 8'h01, 8'h00);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.is_bit) check(e.tag, {7'b0, rd_bit}, e.data);
        else          check(e.tag, rd_data, e.data);
      end
    end
  end

  function automatic int reg_loc(input int n); return m_bank * 8 + n; endfunction
  function automatic int bit_loc(input int ba);
    return (ba < 128) ? 32 + ba / 8 : ba - (ba % 8);
  endfunction
  function automatic logic [7:0] peek(input int a, input bit indirect);
    if (a < 128) return m_lo[a];
    if (indirect) return m_up[a - 128];
    return sfr_mem[a];
  endfunction

  task automatic push(input logic [7:0] d, input logic isb, input string tag);
    exp_t e;
    e.data = d; e.is_bit = isb; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [7:0] wd,
                       input logic bv);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_bit = bv;
  endtask

  task automatic dwr(input logic [7:0] a, input logic [7:0] d);
    drive(3'd1, a, d, 1'b0);
    if (a < 8'h80) m_lo[a] = d;
    else if (a == 8'hD0) m_bank = int'(d[4:3]);
  endtask
  task automatic drd(input logic [7:0] a, input string tag);
    drive(3'd0, a, 8'h00, 1'b0);
    push(peek(int'(a), 1'b0), 1'b0, tag);
  endtask
  task automatic iwr(input int sel, input logic [7:0] d);
    int p;
    drive(3'd3, 8'(sel), d, 1'b0);
    p = int'(m_lo[reg_loc(sel)]);
    if (p < 128) m_lo[p] = d; else m_up[p - 128] = d;
  endtask
  task automatic ird(input int sel, input string tag);
    drive(3'd2, 8'(sel), 8'h00, 1'b0);
    push(peek(int'(m_lo[reg_loc(sel)]), 1'b1), 1'b0, tag);
  endtask
  task automatic rwr(input int n, input logic [7:0] d);
    drive(3'd5, 8'(n), d, 1'b0);
    m_lo[reg_loc(n)] = d;
  endtask
  task automatic rrd(input int n, input string tag);
    drive(3'd4, 8'(n), 8'h00, 1'b0);
    push(m_lo[reg_loc(n)], 1'b0, tag);
  endtask
  task automatic bwr(input int ba, input logic v, input bit ignored_wr);
    int b;
    logic [7:0] nb;
    drive(3'd7, 8'(ba), 8'h00, v);
    b = bit_loc(ba);
    nb = peek(b, 1'b0);
    nb[ba % 8] = v;
    if (b < 128) m_lo[b] = nb;
    else if (b == 'hD0) m_bank = int'(nb[4:3]);
    @(negedge clk);
    check("R9 busy in write-back cycle", {7'b0, busy}, 8'h01);
    if (ignored_wr) begin
      req_valid = 1'b1; req_op = 3'd1; req_addr = 8'h45; req_wdata = 8'hEE;
    end else begin
      req_valid = 1'b0;
    end
  endtask
  task automatic brd(input int ba, input string tag);
    logic [7:0] cur;
    drive(3'd6, 8'(ba), 8'h00, 1'b0);
    cur = peek(bit_loc(ba), 1'b0);
    push({7'b0, cur[ba % 8]}, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin m_lo[i] = 8'h00; m_up[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 busy after reset", {7'b0, busy}, 8'h00);
    check("R1 rd_valid after reset", {7'b0, rd_valid}, 8'h00);

    dwr(8'h00, 8'h11); dwr(8'h08, 8'h22); dwr(8'h10, 8'h33); dwr(8'h18, 8'h44);
    rrd(0, "R1 bank 0 R0 after reset");
    drd(8'h10, "R2 direct lower read");
    rwr(5, 8'hA5);
    drd(8'h05, "R5 bank0 R5 at 05H");

    dwr(8'hD0, 8'h08);
    rrd(0, "R6 bank1 next cycle");
    rwr(7, 8'h77);
    drd(8'h0F, "R5 bank1 R7 at 0FH");
    bwr('hD4, 1'b1, 1'b0);
    rrd(0, "R6 R8 bank3 via bit set D4H");
    bwr('hD3, 1'b0, 1'b0);
    rrd(0, "R6 R8 bank2 via bit clear D3H");

    rwr(0, 8'h30);
    dwr(8'h30, 8'h9C);
    ird(0, "R4 indirect R0 lower");
    rwr(1, 8'hC0);
    iwr(1, 8'h5E);
    ird(1, "R4 indirect R1 upper");
    drd(8'hC0, "R3 R4 direct C0H is window");

    dwr(8'h90, 8'h3C);
    drd(8'h90, "R3 direct window write/read");

    dwr(8'h2F, 8'hFF);
    bwr('h78, 1'b0, 1'b0);
    drd(8'h2F, "R7 R9 bit 78H clears 2FH.0 only");
    bwr('h00, 1'b1, 1'b0);
    drd(8'h20, "R7 bit 00H sets 20H.0");
    bwr('h3B, 1'b1, 1'b0);
    brd('h3B, "R10 bit 3BH reads 1");
    brd('h3A, "R10 bit 3AH reads 0");
    drd(8'h27, "R7 R9 byte 27H after bit 3BH");

    bwr('h95, 1'b0, 1'b0);
    drd(8'h90, "R8 R9 window bit 95H");
    brd('h94, "R8 R10 window bit 94H");

    dwr(8'h45, 8'h12);
    bwr('h10, 1'b1, 1'b1);
    drd(8'h45, "R9 write during busy ignored");
    drd(8'h22, "R7 bit 10H sets 22H.0");

    dwr(8'hD0, 8'h00);
    rrd(0, "R6 back to bank0 next cycle");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 all reads returned", 8'(exp_q.size()), 8'h00);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule